// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A down-counting watchdog for a small system-control subsystem. Software programs a reload value, starts the counter and then services it periodically. When the counter runs out the first time, an interrupt is raised and the count restarts from the reload value. If software still has not serviced the watchdog by the time the count runs out again, the block drives a system reset request, provided reset escalation is enabled.

The reset request is a fixed-length pulse. When the pulse ends, every register of the block returns to its power-up value, so the watchdog is stopped until software starts it again. Register access is a simple single-cycle write strobe with a combinational read port, all in one clock domain.

Register map (word index on `addr_i`): 0 reload value, 1 current count (read only), 2 control, 3 service (write only, any data), 4 status (read only). Control bits: bit 0 run, bit 1 interrupt enable, bit 2 reset enable. Status bits: bit 0 raw pending flag, bit 1 masked interrupt.

Top module: `wdog2`

## Requirements
- R1: After `rst_ni` is low, the reload value and count are `LOAD_INIT` (all ones by default), control and status read 0, and `irq_o` and `sys_rst_o` are low; unmapped indices read 0.
- R2: While control bit 0 (run) is set, the count read at index 1 drops by one on each clock; with run clear it holds.
- R3: On the clock where a running count is 0 and the pending flag is clear, the pending flag (status bit 0) sets and the count reloads from the reload value.
- R4: `irq_o` and status bit 1 are high exactly when the pending flag is set and control bit 1 is set; status bit 0 shows the pending flag regardless of bit 1.
- R5: On the clock where a running count is 0, the pending flag is set and control bit 2 is set, `sys_rst_o` rises after that edge and stays high for exactly `RST_LEN` (default 16) cycles.
- R6: With control bit 2 clear, a second expiry raises no reset; the pending flag stays set and the count reloads.
- R7: A write to index 3 clears the pending flag and reloads the count; it takes priority over an expiry in the same cycle.
- R8: A write to index 0 stores the reload value and loads it into the count on the same edge, taking priority over expiry; the pending flag is unchanged.
- R9: Control bit 0, once set, cannot be cleared by writing 0; bits 1 and 2 follow every control write. A control write takes effect from the next cycle.
- R10: When the reset pulse ends, all registers hold their R1 values.
- R11: While `sys_rst_o` is high, writes are ignored and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Masked interrupt |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench goes after the edge where the count reaches zero: a design that reloads one cycle late or skips the zero state drifts from the expected count and raises the interrupt off-cycle. It collides service and reload writes with expiry, where a wrong priority would let a reset escape despite servicing. It runs second expiries with reset escalation both on and off, counts the pulse length, and reads every register after the pulse, catching a pulse that is one cycle short, a reset fired while disabled, or state that survives the pulse. Writes during the pulse and attempts to clear the run bit check that neither takes hold.

// File: rtl/wdog2.sv
module wdog2 #(
  parameter int W = 32,
  parameter logic [W-1:0] LOAD_INIT = '1,
  parameter int RST_LEN = 16,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          irq_o,
  output logic          sys_rst_o
);
  localparam int PW = $clog2(RST_LEN + 1);
  localparam logic [AW-1:0] A_LOAD = 0, A_CNT = 1, A_CTRL = 2, A_SVC = 3, A_STAT = 4;

  logic [W-1:0]  load_q, cnt_q;
  logic          run_q, ien_q, ren_q, pend_q;
  logic [PW-1:0] pulse_q;

  wire expire = run_q && (cnt_q == '0);
  wire wr_load = wr_i && addr_i == A_LOAD;
  wire wr_svc  = wr_i && addr_i == A_SVC;
  wire wr_ctrl = wr_i && addr_i == A_CTRL;

  assign sys_rst_o = pulse_q != '0;
  assign irq_o     = pend_q & ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= LOAD_INIT; cnt_q <= LOAD_INIT;
      run_q <= 1'b0; ien_q <= 1'b0; ren_q <= 1'b0; pend_q <= 1'b0;
      pulse_q <= '0;
    end else if (pulse_q == PW'(1)) begin
      load_q <= LOAD_INIT; cnt_q <= LOAD_INIT;
      run_q <= 1'b0; ien_q <= 1'b0; ren_q <= 1'b0; pend_q <= 1'b0;
      pulse_q <= '0;
    end else if (pulse_q != '0) begin
      pulse_q <= pulse_q - PW'(1);
    end else begin
      if (wr_ctrl) begin
        run_q <= run_q | wdata_i[0];
        ien_q <= wdata_i[1];
        ren_q <= wdata_i[2];
      end
      if (wr_load) begin
        load_q <= wdata_i;
        cnt_q  <= wdata_i;
      end else if (wr_svc) begin
        cnt_q  <= load_q;
        pend_q <= 1'b0;
      end else if (expire) begin
        cnt_q <= load_q;
        if (!pend_q)    pend_q  <= 1'b1;
        else if (ren_q) pulse_q <= PW'(RST_LEN);
      end else if (run_q) begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LOAD: rdata_o = load_q;
      A_CNT:  rdata_o = cnt_q;
      A_CTRL: rdata_o = W'({ren_q, ien_q, run_q});
      A_STAT: rdata_o = W'({irq_o, pend_q});
      default: rdata_o = '0;
    endcase
  end
endmodule

module wdog2_chk #(
  parameter int W = 32,
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  cnt_q,
  input logic          run_q,
  input logic          ien_q,
  input logic          ren_q,
  input logic          pend_q,
  input logic          irq_o,
  input logic          sys_rst_o
);
  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_q != '0 && !wr_i && !sys_rst_o |=> cnt_q == $past(cnt_q) - W'(1));
  // R4
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ien_q && pend_q);
  // R5
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(pend_q) && $past(ren_q) && $past(cnt_q) == '0);
  // R6
  no_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_q == '0 && pend_q && !ren_q && !wr_i && !sys_rst_o |=> !sys_rst_o && pend_q);
  // R9
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !sys_rst_o |=> run_q);
  // R11
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o && $past(sys_rst_o) |-> $stable(cnt_q));
endmodule

bind wdog2 wdog2_chk #(.W(W), .AW(AW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .cnt_q(cnt_q), .run_q(run_q), .ien_q(ien_q), .ren_q(ren_q), .pend_q(pend_q),
  .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/wdog2_tb_top.sv
module wdog2_tb_top;
  logic clk = 0, rst_n = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, srst;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog2 dut_i (.clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
               .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst));

  logic [31:0] m_load, m_cnt;
  logic [2:0]  m_ctrl;
  logic        m_pend;
  int          m_rc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || m_rc == 1) begin
      m_load <= '1; m_cnt <= '1; m_ctrl <= 0; m_pend <= 0; m_rc <= 0;
    end else if (m_rc != 0) m_rc <= m_rc - 1;
    else begin
      if (wr && addr == 2) m_ctrl <= {wdata[2:1], m_ctrl[0] | wdata[0]};
      if (wr && addr == 0) begin m_load <= wdata; m_cnt <= wdata; end
      else if (wr && addr == 3) begin m_cnt <= m_load; m_pend <= 0; end
      else if (m_ctrl[0]) begin
        if (m_cnt == 0) begin
          m_cnt <= m_load;
          if (!m_pend) m_pend <= 1; else if (m_ctrl[2]) m_rc <= 16;
        end else m_cnt <= m_cnt - 1;
      end
    end
  end

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      0: return m_load;
      1: return m_cnt;
      2: return {29'b0, m_ctrl};
      4: return {30'b0, m_pend & m_ctrl[1], m_pend};
      default: return 0;
    endcase
  endfunction

  function automatic string rtag(input logic [2:0] a);
    case (a)
      0: return "R8"; 1: return "R2"; 2: return "R9"; 4: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R4", 32'(irq), 32'(m_pend & m_ctrl[1]));
    chk("R5", 32'(srst), 32'(m_rc != 0));
    chk(rtag(addr), rdata, mread(addr));
  endtask

  task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d);
    wr = w; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 0;
    cmp_all();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R1", rdata, (a < 2) ? 32'hFFFF_FFFF : 32'h0);
    end
    chk("R1", {30'b0, irq, srst}, 0);

    // directed: first then second expiry with reset enabled
    cyc(1, 0, 4);
    cyc(1, 2, 7);
    addr = 1;
    for (int i = 0; i < 6; i++) cyc(0, 1, 0);
    addr = 4; #1; chk("R3", rdata[0], 1);
    hi = 0;
    for (int i = 0; i < 30; i++) begin cyc(0, 4, 0); if (srst) hi++; end
    chk("R5", hi, 16);
    cyc(0, 2, 0); chk("R10", rdata, 0);
    cyc(0, 0, 0); chk("R10", rdata, 32'hFFFF_FFFF);

    // second expiry with reset disabled, sticky run
    cyc(1, 0, 2);
    cyc(1, 2, 3);
    cyc(1, 2, 2);
    addr = 2; #1; chk("R9", rdata, 3);
    hi = 0;
    for (int i = 0; i < 20; i++) begin cyc(0, 4, 0); if (srst) hi++; end
    chk("R6", hi, 0);
    chk("R6", rdata[0], 1);
    cyc(1, 3, 0); chk("R7", rdata[0], 0);

    // random mix
    for (int i = 0; i < 5000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 6) cyc(1, 0, $urandom_range(0, 12));
      else if (r < 9) cyc(1, 2, $urandom_range(0, 7));
      else if (r < 15) cyc(1, 3, $urandom);
      else cyc(0, 3'($urandom_range(0, 7)), 0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule